// File: doc/BRIEF.md
# Trigger-Coherent NCO Down-Converter

This block shifts a real sample stream down to complex baseband. A numerically controlled oscillator runs a 16-bit phase accumulator that advances by a frequency word on every valid input sample. The oscillator frequency is therefore N × Fs / 65536. The top bits of the phase read a quarter-wave sine table, which supplies both the cosine and the sine. Two multipliers then form the in-phase product (sample times cosine) and the quadrature product (sample times negative sine). Each product is rounded and saturated to 16 bits. A bypass control sends samples straight through to the I output instead, so a later decimation stage can still work on raw data.

Each receive line can start with the same oscillator phase. When the reset-on-trigger mode is selected, a transmit trigger forces the phase to zero. The trigger comes from a hardware pin or from a self-clearing software trigger bit. The frequency word comes either from a register value or from a value supplied by a profile.

Phase control is a three-state sequencer:
- SEQ_FREE: continuous mode. Triggers are ignored.
- SEQ_LOCK: reset-on-trigger mode, running with no trigger pending.
- SEQ_ARMED: a trigger arrived in a cycle with no sample. The accumulator is already zero, and the next valid sample uses phase 0.

The transitions are:
- FREE→LOCK when the mode bit rises.
- FREE→ARMED or LOCK→ARMED on a trigger without a sample while the mode bit is set.
- ARMED→LOCK on the next valid sample.
- Any state→FREE when the mode bit falls.

Top module: `nco_downmix`

## Requirements
- R1: The phase used by a valid sample advances by the selected 16-bit frequency word for the next valid sample, wrapping modulo 65536. Cycles without a valid sample leave the phase unchanged.
- R2: `freq_manual`=1 selects `freq_word_reg` as the frequency word. `freq_manual`=0 selects `freq_word_prof`. The selection is sampled together with each sample.
- R3: The table phase p is the top 10 bits of the 16-bit phase. The cosine is round(32767·cos(2πp/1024)) and the sine is round(32767·sin(2πp/1024)), with rounding away from zero at one half.
- R4: I = sat16(floor((x·cos + 2048) / 4096)) and Q = sat16(floor((−x·sin + 2048) / 4096)). Results outside [−32768, 32767] clamp to the nearest limit.
- R5: A sample presented with `smp_vld`=1 in cycle n produces its I/Q in cycle n+3, with `out_vld`=1 in that cycle only.
- R6: While `out_vld`=0, `i_out` and `q_out` keep their last values.
- R7: With `zero_on_trig`=1, a trigger in the same cycle as a valid sample makes that sample use phase 0. The next sample uses phase N.
- R8: With `zero_on_trig`=1, a trigger in a cycle without a sample makes the next valid sample use phase 0, however many idle cycles follow.
- R9: With `zero_on_trig`=0, triggers have no effect on the phase.
- R10: `sw_trig_wr`=1 in cycle n acts as a trigger in cycle n+1 only.
- R11: `mix_bypass`=1, sampled with the sample, gives I = x sign-extended and Q = 0 with the same latency. The phase keeps advancing during bypass.
- R12: During and right after reset, `out_vld`=0, `i_out`=0 and `q_out`=0, and the first sample uses phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_in | input | 14 | Signed input sample |
| smp_vld | input | 1 | Sample qualifier |
| freq_word_reg | input | 16 | Register frequency word |
| freq_word_prof | input | 16 | Profile frequency word |
| freq_manual | input | 1 | 1 = register word, 0 = profile word |
| trig_pin | input | 1 | Hardware transmit trigger pulse |
| sw_trig_wr | input | 1 | Write strobe of the self-clearing trigger bit |
| zero_on_trig | input | 1 | 1 = zero phase on trigger, 0 = continuous |
| mix_bypass | input | 1 | 1 = pass samples without mixing |
| i_out | output | 16 | Signed in-phase result |
| q_out | output | 16 | Signed quadrature result |
| out_vld | output | 1 | Result qualifier |

## Verification
The assertions check the following on every cycle:
- the three-cycle valid latency;
- that the outputs hold while the output qualifier is low;
- the bypass data path;
- the accumulator loading the frequency word after a same-cycle trigger;
- the accumulator being zero while a trigger is pending;
- plain accumulation in continuous mode.

The numeric content of the products can only be shown by the bench's scenarios: table values in all four quadrants, rounding, saturation at both rails, and source selection. The same holds for the one-cycle delay of the software trigger and the end-to-end coherence of the first sample after a trigger.

// File: rtl/nco_pkg.sv
package nco_pkg;

    typedef enum logic [1:0] {
        SEQ_FREE  = 2'd0,
        SEQ_LOCK  = 2'd1,
        SEQ_ARMED = 2'd2
    } seq_state_t;

    // Amplitude-scaled sine of (pi/2)*k/steps, rounded; evaluated at elaboration.
    function automatic int quarter_sine(input int k, input int steps, input int amp);
        real ang;
        real term;
        real acc;
        ang  = 3.14159265358979323846 * real'(k) / (2.0 * real'(steps));
        term = ang;
        acc  = ang;
        for (int i = 1; i < 12; i++) begin
            term = -term * ang * ang / (real'(2 * i) * real'(2 * i + 1));
            acc  = acc + term;
        end
        return $rtoi(real'(amp) * acc + 0.5);
    endfunction

endpackage

// File: rtl/nco_trig_seq.sv
module nco_trig_seq
    import nco_pkg::*;
#(
    parameter int PH_W     = 16,
    parameter int OUT_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld,
    input  logic [PH_W-1:0]     freq_word,
    input  logic                trig_pin,
    input  logic                sw_trig_wr,
    input  logic                zero_on_trig,
    output logic [OUT_BITS-1:0] phase_top,
    output logic [PH_W-1:0]     acc_o,
    output seq_state_t          state_o
);

    seq_state_t      state_q, state_d;
    logic            sw_pulse_q;
    logic            trig;
    logic            force_zero;
    logic [PH_W-1:0] acc_q;
    logic [PH_W-1:0] phase_used;

    // self-clearing software trigger: one pulse, one cycle after the write
    always_ff @(posedge clk) begin
        if (!rst_n) sw_pulse_q <= 1'b0;
        else        sw_pulse_q <= sw_trig_wr;
    end

    assign trig = trig_pin | sw_pulse_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_FREE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_FREE: begin
                if (zero_on_trig && trig && !smp_vld) state_d = SEQ_ARMED;
                else if (zero_on_trig)                state_d = SEQ_LOCK;
            end
            SEQ_LOCK: begin
                if (!zero_on_trig)          state_d = SEQ_FREE;
                else if (trig && !smp_vld)  state_d = SEQ_ARMED;
            end
            SEQ_ARMED: begin
                if (!zero_on_trig)  state_d = SEQ_FREE;
                else if (smp_vld)   state_d = SEQ_LOCK;
            end
            default: state_d = SEQ_FREE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        force_zero = 1'b0;
        unique case (state_q)
            SEQ_FREE:  force_zero = zero_on_trig && trig;
            SEQ_LOCK:  force_zero = zero_on_trig && trig;
            SEQ_ARMED: force_zero = zero_on_trig;
            default:   force_zero = 1'b0;
        endcase
    end

    assign phase_used = force_zero ? '0 : acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          acc_q <= '0;
        else if (smp_vld)    acc_q <= phase_used + freq_word;
        else if (force_zero) acc_q <= '0;
    end

    assign phase_top = phase_used[PH_W-1 -: OUT_BITS];
    assign acc_o     = acc_q;
    assign state_o   = state_q;

endmodule

// File: rtl/nco_sincos.sv
module nco_sincos
    import nco_pkg::*;
#(
    parameter int PH_BITS = 10,
    parameter int AMP_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [PH_BITS-1:0]      phase,
    output logic signed [AMP_W-1:0] cos_o,
    output logic signed [AMP_W-1:0] sin_o
);

    localparam int QB   = PH_BITS - 2;
    localparam int QLEN = 1 << QB;
    localparam int AMP  = (1 << (AMP_W - 1)) - 1;
    localparam logic [QB:0] QTOP = (QB + 1)'(QLEN);

    logic [AMP_W-1:0]        qtab [QLEN+1];
    logic signed [AMP_W-1:0] rd   [2];

    for (genvar k = 0; k <= QLEN; k++) begin : g_tab
        localparam int V = quarter_sine(k, QLEN, AMP);
        assign qtab[k] = AMP_W'(V);
    end

    // port 0 reads a quarter turn ahead (cosine), port 1 reads the sine
    for (genvar p = 0; p < 2; p++) begin : g_port
        logic [PH_BITS-1:0] ph;
        logic [QB:0]        sel;
        logic [AMP_W-1:0]   mag;
        assign ph  = phase + PH_BITS'(p == 0 ? QLEN : 0);
        assign sel = ph[QB] ? (QTOP - {1'b0, ph[QB-1:0]}) : {1'b0, ph[QB-1:0]};
        assign mag = qtab[sel];
        assign rd[p] = ph[PH_BITS-1] ? -$signed(mag) : $signed(mag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cos_o <= '0;
            sin_o <= '0;
        end else if (en) begin
            cos_o <= rd[0];
            sin_o <= rd[1];
        end
    end

endmodule

// File: rtl/nco_mix_lane.sv
module nco_mix_lane #(
    parameter int DIN_W  = 14,
    parameter int COEF_W = 16,
    parameter int DOUT_W = 16,
    parameter int SHIFT  = 12,
    parameter bit NEGATE = 1'b0,
    parameter bit PASS_X = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     byp,
    input  logic signed [DIN_W-1:0]  x,
    input  logic signed [COEF_W-1:0] coef,
    output logic signed [DOUT_W-1:0] y
);

    localparam int PW = DIN_W + COEF_W + 1;
    localparam logic signed [PW-1:0] HI   = PW'(2 ** (DOUT_W - 1) - 1);
    localparam logic signed [PW-1:0] LO   = ~HI;
    localparam logic signed [PW-1:0] HALF = PW'(2 ** (SHIFT - 1));

    logic signed [PW-1:0]     xe, ce, prod, sgn, rnd, shd;
    logic signed [DOUT_W-1:0] sat, passv, nxt;

    assign xe   = PW'(x);
    assign ce   = PW'(coef);
    assign prod = xe * ce;

    if (NEGATE) begin : g_neg
        assign sgn = -prod;
    end else begin : g_pos
        assign sgn = prod;
    end

    assign rnd = sgn + HALF;
    assign shd = rnd >>> SHIFT;

    always_comb begin
        if (shd > HI)      sat = HI[DOUT_W-1:0];
        else if (shd < LO) sat = LO[DOUT_W-1:0];
        else               sat = shd[DOUT_W-1:0];
    end

    if (PASS_X) begin : g_pass
        assign passv = DOUT_W'(x);
    end else begin : g_zero
        assign passv = '0;
    end

    assign nxt = byp ? passv : sat;

    always_ff @(posedge clk) begin
        if (!rst_n)  y <= '0;
        else if (en) y <= nxt;
    end

endmodule

// File: rtl/nco_downmix.sv
module nco_downmix
    import nco_pkg::*;
#(
    parameter int DIN_W    = 14,
    parameter int PH_W     = 16,
    parameter int LUT_BITS = 10,
    parameter int COEF_W   = 16,
    parameter int DOUT_W   = 16,
    parameter int SHIFT    = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DIN_W-1:0]  smp_in,
    input  logic                     smp_vld,
    input  logic [PH_W-1:0]          freq_word_reg,
    input  logic [PH_W-1:0]          freq_word_prof,
    input  logic                     freq_manual,
    input  logic                     trig_pin,
    input  logic                     sw_trig_wr,
    input  logic                     zero_on_trig,
    input  logic                     mix_bypass,
    output logic signed [DOUT_W-1:0] i_out,
    output logic signed [DOUT_W-1:0] q_out,
    output logic                     out_vld
);

    logic [PH_W-1:0]     freq_word;
    logic [LUT_BITS-1:0] phase_now;
    logic [PH_W-1:0]     ph_acc;
    seq_state_t          seq_state;

    assign freq_word = freq_manual ? freq_word_reg : freq_word_prof;

    nco_trig_seq #(.PH_W(PH_W), .OUT_BITS(LUT_BITS)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_vld      (smp_vld),
        .freq_word    (freq_word),
        .trig_pin     (trig_pin),
        .sw_trig_wr   (sw_trig_wr),
        .zero_on_trig (zero_on_trig),
        .phase_top    (phase_now),
        .acc_o        (ph_acc),
        .state_o      (seq_state)
    );

    // stage A: capture sample and phase
    logic                    a_vld, a_byp;
    logic signed [DIN_W-1:0] a_x;
    logic [LUT_BITS-1:0]     a_ph;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_vld <= 1'b0;
            a_byp <= 1'b0;
            a_x   <= '0;
            a_ph  <= '0;
        end else begin
            a_vld <= smp_vld;
            if (smp_vld) begin
                a_x   <= smp_in;
                a_ph  <= phase_now;
                a_byp <= mix_bypass;
            end
        end
    end

    // stage B: table read
    logic signed [COEF_W-1:0] b_cos, b_sin;
    logic                     b_vld, b_byp;
    logic signed [DIN_W-1:0]  b_x;

    nco_sincos #(.PH_BITS(LUT_BITS), .AMP_W(COEF_W)) lut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (a_vld),
        .phase (a_ph),
        .cos_o (b_cos),
        .sin_o (b_sin)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_vld <= 1'b0;
            b_byp <= 1'b0;
            b_x   <= '0;
        end else begin
            b_vld <= a_vld;
            if (a_vld) begin
                b_x   <= a_x;
                b_byp <= a_byp;
            end
        end
    end

    // stage C: multiply, round, saturate
    nco_mix_lane #(.DIN_W(DIN_W), .COEF_W(COEF_W), .DOUT_W(DOUT_W), .SHIFT(SHIFT),
                   .NEGATE(1'b0), .PASS_X(1'b1)) lane_i (
        .clk (clk), .rst_n (rst_n), .en (b_vld), .byp (b_byp),
        .x (b_x), .coef (b_cos), .y (i_out)
    );

    nco_mix_lane #(.DIN_W(DIN_W), .COEF_W(COEF_W), .DOUT_W(DOUT_W), .SHIFT(SHIFT),
                   .NEGATE(1'b1), .PASS_X(1'b0)) lane_q (
        .clk (clk), .rst_n (rst_n), .en (b_vld), .byp (b_byp),
        .x (b_x), .coef (b_sin), .y (q_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= b_vld;
    end

endmodule

// File: rtl/nco_downmix_chk.sv
module nco_downmix_chk
    import nco_pkg::*;
#(
    parameter int DIN_W  = 14,
    parameter int PH_W   = 16,
    parameter int DOUT_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic signed [DIN_W-1:0]  smp_in,
    input logic                     smp_vld,
    input logic [PH_W-1:0]          freq_word_reg,
    input logic [PH_W-1:0]          freq_word_prof,
    input logic                     freq_manual,
    input logic                     trig_pin,
    input logic                     zero_on_trig,
    input logic                     mix_bypass,
    input logic signed [DOUT_W-1:0] i_out,
    input logic signed [DOUT_W-1:0] q_out,
    input logic                     out_vld,
    input logic [PH_W-1:0]          ph_acc,
    input seq_state_t               seq_state
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n)         age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (out_vld == $past(smp_vld, 3)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) && !out_vld |-> ($stable(i_out) && $stable(q_out)));

    assert_bypass_path_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) && out_vld && $past(mix_bypass, 3)
        |-> (q_out == '0) && (i_out == DOUT_W'($past(smp_in, 3))));

    assert_trig_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        zero_on_trig && trig_pin && smp_vld
        |=> ph_acc == $past(freq_manual ? freq_word_reg : freq_word_prof));

    assert_armed_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_ARMED) |-> (ph_acc == '0));

    assert_continuous_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_on_trig && smp_vld
        |=> ph_acc == PH_W'($past(ph_acc) + $past(freq_manual ? freq_word_reg : freq_word_prof)));

endmodule

bind nco_downmix nco_downmix_chk #(.DIN_W(DIN_W), .PH_W(PH_W), .DOUT_W(DOUT_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .smp_in         (smp_in),
    .smp_vld        (smp_vld),
    .freq_word_reg  (freq_word_reg),
    .freq_word_prof (freq_word_prof),
    .freq_manual    (freq_manual),
    .trig_pin       (trig_pin),
    .zero_on_trig   (zero_on_trig),
    .mix_bypass     (mix_bypass),
    .i_out          (i_out),
    .q_out          (q_out),
    .out_vld        (out_vld),
    .ph_acc         (ph_acc),
    .seq_state      (seq_state)
);

// File: tb/nco_downmix_tb.sv
module nco_downmix_tb_top;

    localparam time CLK_P = 10ns;
    localparam real PI    = 3.14159265358979323846;
    localparam int  NVEC  = 12;
    localparam int  XV [NVEC] = '{1000, -1000, 8191, -8192, 8191, -8192,
                                  4095, -4096, 7000, -7000, 123, -8192};
    localparam int  NV [NVEC] = '{4096, 4096, 8192, 8192, 16384, 16384,
                                  12288, 2048, 32768, 40000, 65535, 0};

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [13:0] smp_in = '0;
    logic               smp_vld = 1'b0;
    logic [15:0]        freq_word_reg = '0;
    logic [15:0]        freq_word_prof = '0;
    logic               freq_manual = 1'b0;
    logic               trig_pin = 1'b0;
    logic               sw_trig_wr = 1'b0;
    logic               zero_on_trig = 1'b0;
    logic               mix_bypass = 1'b0;
    logic signed [15:0] i_out, q_out;
    logic               out_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench-side model state
    int    acc_m = 0;
    bit    armed_m = 1'b0;
    bit    sw_prev = 1'b0;
    bit    pv [3];
    int    pi_ [3];
    int    pq [3];
    string ptag [3];
    int    last_i = 0;
    int    last_q = 0;

    always #(CLK_P / 2) clk = ~clk;

    nco_downmix dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .smp_in         (smp_in),
        .smp_vld        (smp_vld),
        .freq_word_reg  (freq_word_reg),
        .freq_word_prof (freq_word_prof),
        .freq_manual    (freq_manual),
        .trig_pin       (trig_pin),
        .sw_trig_wr     (sw_trig_wr),
        .zero_on_trig   (zero_on_trig),
        .mix_bypass     (mix_bypass),
        .i_out          (i_out),
        .q_out          (q_out),
        .out_vld        (out_vld)
    );

    function automatic int rnd(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    function automatic int sat16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int mixv(input int x, input int coef, input bit neg);
        longint pr;
        pr = longint'(x) * longint'(coef);
        if (neg) pr = -pr;
        return sat16((pr + 2048) >>> 12);
    endfunction

    task automatic note(input string tag, input bit ok, input int act, input int exp_v, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp_v);
        end
    endtask

    // one cycle: check the result due now, then drive the next inputs and model them
    task automatic step(input int x, input bit vld, input bit tp, input bit sw, input bit byp,
                        input bit zm, input bit man, input int nreg, input int nprof,
                        input string tag);
        int  ei, eq, n, ph, p, c, s;
        bit  trig, frc;
        string t;
        @(negedge clk);
        t = pv[2] ? ptag[2] : tag;
        if (pv[2]) begin
            last_i = pi_[2];
            last_q = pq[2];
        end
        ei = last_i;
        eq = last_q;
        note(t, (out_vld == pv[2]) && (int'(i_out) == ei) && (int'(q_out) == eq),
             int'(i_out), ei, "i_out");
        if (!((out_vld == pv[2]) && (int'(i_out) == ei) && (int'(q_out) == eq)))
            $display("     detail %s: q_out %0d/%0d out_vld %0d/%0d", t, int'(q_out), eq,
                     out_vld, pv[2]);
        smp_in         = 14'(x);
        smp_vld        = vld;
        trig_pin       = tp;
        sw_trig_wr     = sw;
        mix_bypass     = byp;
        zero_on_trig   = zm;
        freq_manual    = man;
        freq_word_reg  = 16'(nreg);
        freq_word_prof = 16'(nprof);
        trig    = tp || sw_prev;
        sw_prev = sw;
        n       = man ? (nreg & 16'hFFFF) : (nprof & 16'hFFFF);
        frc     = zm && (trig || armed_m);
        ph      = frc ? 0 : acc_m;
        if (vld)      acc_m = (ph + n) & 16'hFFFF;
        else if (frc) acc_m = 0;
        armed_m = zm && !vld && (trig || armed_m);
        p = ph >> 6;
        c = rnd(32767.0 * $cos(2.0 * PI * real'(p) / 1024.0));
        s = rnd(32767.0 * $sin(2.0 * PI * real'(p) / 1024.0));
        pv[2] = pv[1]; pi_[2] = pi_[1]; pq[2] = pq[1]; ptag[2] = ptag[1];
        pv[1] = pv[0]; pi_[1] = pi_[0]; pq[1] = pq[0]; ptag[1] = ptag[0];
        pv[0]   = vld;
        ptag[0] = tag;
        pi_[0]  = byp ? x : mixv(x, c, 1'b0);
        pq[0]   = byp ? 0 : mixv(x, s, 1'b1);
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            pv[k] = 1'b0; pi_[k] = 0; pq[k] = 0; ptag[k] = "R12";
        end
        // R12: reset state
        repeat (3) @(negedge clk);
        note("R12", out_vld == 1'b0, int'(out_vld), 0, "out_vld in reset");
        note("R12", i_out == '0, int'(i_out), 0, "i_out in reset");
        note("R12", q_out == '0, int'(q_out), 0, "q_out in reset");
        rst_n = 1'b1;

        // R12: first sample after reset uses phase 0 (x*32767 path)
        step(3000, 1, 0, 0, 0, 0, 1, 4096, 0, "R12");

        // vector table: mixing arithmetic, rounding and saturation (R4)
        for (int v = 0; v < NVEC; v++)
            step(XV[v], 1, 0, 0, 0, 0, 1, NV[v], 0, "R4");

        // R3: full turn in 22.5 degree steps starting from a pin trigger
        step(4000, 1, 1, 0, 0, 1, 1, 4096, 0, "R3");
        for (int k = 0; k < 16; k++)
            step(-4000 + 500 * k, 1, 0, 0, 0, 1, 1, 4096, 0, "R3");

        // R1: wrap-around with a large word and an odd word
        for (int k = 0; k < 6; k++)
            step(5000, 1, 0, 0, 0, 0, 1, 16'hC000, 0, "R1");
        for (int k = 0; k < 5; k++)
            step(-2500, 1, 0, 0, 0, 0, 1, 16'h7FC1, 0, "R1");

        // R2: source select
        for (int k = 0; k < 4; k++)
            step(6000, 1, 0, 0, 0, 0, 0, 30000, 2048, "R2");
        for (int k = 0; k < 4; k++)
            step(6000, 1, 0, 0, 0, 0, 1, 30000, 2048, "R2");

        // R5 / R6: gaps in the sample stream
        step(7000, 1, 0, 0, 0, 0, 1, 3000, 0, "R5");
        step(1111, 0, 0, 0, 0, 0, 1, 3000, 0, "R6");
        step(2222, 0, 0, 0, 0, 0, 1, 3000, 0, "R6");
        step(-7000, 1, 0, 0, 0, 0, 1, 3000, 0, "R5");
        step(3333, 0, 0, 0, 0, 0, 1, 3000, 0, "R6");
        step(2500, 1, 0, 0, 0, 0, 1, 3000, 0, "R5");
        for (int k = 0; k < 4; k++)
            step(4444, 0, 0, 0, 0, 0, 1, 3000, 0, "R6");

        // R7: same-cycle trigger zeroes the phase
        for (int k = 0; k < 3; k++)
            step(5000, 1, 0, 0, 0, 1, 1, 5000, 0, "R7");
        step(5000, 1, 1, 0, 0, 1, 1, 5000, 0, "R7");
        step(5000, 1, 0, 0, 0, 1, 1, 5000, 0, "R7");

        // R8: trigger on an idle cycle, sample several cycles later
        step(5000, 1, 0, 0, 0, 1, 1, 7000, 0, "R8");
        step(0, 0, 1, 0, 0, 1, 1, 7000, 0, "R8");
        step(0, 0, 0, 0, 0, 1, 1, 7000, 0, "R8");
        step(0, 0, 0, 0, 0, 1, 1, 7000, 0, "R8");
        step(5000, 1, 0, 0, 0, 1, 1, 7000, 0, "R8");
        step(5000, 1, 0, 0, 0, 1, 1, 7000, 0, "R8");

        // R9: continuous mode ignores triggers
        for (int k = 0; k < 3; k++)
            step(5000, 1, 0, 0, 0, 0, 1, 9000, 0, "R9");
        step(5000, 1, 1, 0, 0, 0, 1, 9000, 0, "R9");
        step(5000, 0, 1, 0, 0, 0, 1, 9000, 0, "R9");
        step(5000, 1, 0, 1, 0, 0, 1, 9000, 0, "R9");
        step(5000, 1, 0, 0, 0, 0, 1, 9000, 0, "R9");

        // R10: software trigger acts one cycle after the write, once
        for (int k = 0; k < 3; k++)
            step(6000, 1, 0, 0, 0, 1, 1, 6000, 0, "R10");
        step(6000, 1, 0, 1, 0, 1, 1, 6000, 0, "R10");
        step(6000, 1, 0, 0, 0, 1, 1, 6000, 0, "R10");
        step(6000, 1, 0, 0, 0, 1, 1, 6000, 0, "R10");
        step(6000, 1, 0, 0, 0, 1, 1, 6000, 0, "R10");

        // R11: bypass passes samples and the phase keeps running
        step(-8192, 1, 0, 0, 1, 0, 1, 10000, 0, "R11");
        step(8191, 1, 0, 0, 1, 0, 1, 10000, 0, "R11");
        step(-5, 1, 0, 0, 1, 0, 1, 10000, 0, "R11");
        step(7000, 1, 0, 0, 0, 0, 1, 10000, 0, "R11");
        step(7000, 1, 0, 0, 0, 0, 1, 10000, 0, "R11");

        for (int k = 0; k < 4; k++)
            step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R6");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule